// File: doc/BRIEF.md
# Programmable priority interrupt controller

This block gathers eight interrupt request lines, remembers each rising edge as a pending request, and signals a processor on one interrupt output. Pending requests are ranked by a fixed priority, where input 0 ranks highest. The processor reaches the block through a byte-wide write port with one address bit. A0 low selects the command port and A0 high selects the data port. When the processor acknowledges an interrupt, the highest-ranked unmasked request moves into the in-service register. The block then returns an 8-bit vector, formed from a programmed base and the input number.

Software must set the block up with an initialization sequence before it will raise interrupts. The sequence opens with a command word. It then takes a vector base, an optional cascade word and an optional mode word. The cascade word is read differently in the master role and in the slave role, and the block only stores and reports it. Once initialization is complete, data-port writes update the mask register. Command-port writes can retire in-service bits, either the highest-ranked one or one picked by number.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, int_o is 0, vector_o is 0x00 and cascade_cfg_o is 0x00. Until the first initialization sequence completes, int_o stays 0 whatever the request inputs do.
- R2: A command-port write (a0_i=0) with bit 4 set starts initialization. It clears the request, in-service, mask and cascade registers. From then until initialization completes, int_o stays 0 and every data-port write is taken as the next initialization word.
- R3: The first data-port word after the start word is the vector base. Its bits 7:3 become vector bits 7:3, and vector bits 2:0 carry the input number (a base of 0x20 gives 0x20 to 0x27).
- R4: In the start word, bit 1 = 0 selects cascade mode, and a cascade word then follows the base. With role_master_i=1, cascade_cfg_o shows the whole word. With role_master_i=0, it shows only bits 2:0 (the slave ID) and the upper bits read 0. With bit 1 = 1, no cascade word is taken and cascade_cfg_o stays 0x00.
- R5: In the start word, bit 0 = 1 means a mode word follows, and initialization completes when it is written. With bit 0 = 0, initialization completes on the base word, or on the cascade word if one is expected.
- R6: After initialization, a data-port write loads all 8 mask bits at once, and a 1 masks that input. A masked request stays pending and raises int_o as soon as its mask bit is cleared.
- R7: A request bit is set only on a rising edge of its input. An input held high produces a single request.
- R8: Input 0 has the highest priority. int_o is 1 exactly when initialization is complete and the highest-priority unmasked pending request ranks strictly above every set in-service bit.
- R9: An acknowledge pulse (inta_i high for one cycle) moves the highest-priority unmasked pending request into the in-service register and clears its request bit. On the next cycle, vector_o shows base plus the input number. If nothing is pending, vector_o shows base plus 7 and no register changes.
- R10: The command value 0x20 (bits 7:5 = 001, bits 4:3 = 0) clears the highest-priority set in-service bit.
- R11: The command value 0x60 plus n (bits 7:5 = 011, bits 4:3 = 0) clears in-service bit n, whatever its priority.
- R12: A mask write never changes the in-service register. A masked in-service bit still blocks lower-priority requests, and an end-of-interrupt still clears it.
- R13: After initialization, a command-port write with bit 4 = 0 whose bits 7:5 are neither 001 nor 011, or whose bit 3 is set, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per word |
| a0_i | input | 1 | Port select: 0 = command port, 1 = data port |
| wdata_i | input | 8 | Write data |
| irq_i | input | 8 | Interrupt request inputs, rising-edge sensitive |
| role_master_i | input | 1 | 1 = master role, 0 = slave role (affects cascade word reporting) |
| inta_i | input | 1 | Interrupt acknowledge pulse |
| int_o | output | 1 | Interrupt output |
| vector_o | output | 8 | Vector of the last acknowledge |
| cascade_cfg_o | output | 8 | Stored cascade word (master mask or slave ID) |

## Verification
Requests are raised in several orders: a lower-priority input while a higher one is in service, a higher one while a lower one is in service, a request held high, and a request that arrives while masked. Each order shows whether blocking by in-service bits and edge latching are resolved correctly. End-of-interrupt commands are issued with two in-service bits set, and the next request is chosen so that clearing the wrong bit changes int_o. This separates the nonspecific form from the specific form. Three initialization variants are run: cascaded master with a mode word, cascaded slave, and single mode without a mode word. They confirm word counting, cascade word reporting in each role, and that the init words never leak into the mask.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_CASC,
    INIT_MODE,
    INIT_RUN
  } init_st_e;

  localparam logic [2:0] OP_EOI_NS = 3'b001;
  localparam logic [2:0] OP_EOI_SP = 3'b011;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             clr_all_i,
  input  logic [N_IRQ-1:0] ack_clr_i,
  output logic [N_IRQ-1:0] irr_o
);
  logic [N_IRQ-1:0] irq_q;
  logic [N_IRQ-1:0] rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_o <= '0;
    end else begin
      irq_q <= irq_i;
      if (clr_all_i) irr_o <= '0;
      else           irr_o <= (irr_o & ~ack_clr_i) | rise;
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] vec_i,
  output logic             vld_o,
  output logic [IW-1:0]    idx_o,
  output logic [N_IRQ-1:0] oh_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign vld_o = |vec_i;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_oh
    assign oh_o[g] = vld_o && (idx_o == IW'(g));
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = $clog2(N_IRQ),
  localparam int unsigned BW = N_IRQ - IW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             a0_i,
  input  logic [N_IRQ-1:0] wdata_i,
  input  logic             role_master_i,
  output logic             running_o,
  output logic             init_start_o,
  output logic [BW-1:0]    base_o,
  output logic [N_IRQ-1:0] cfg_o,
  output logic [N_IRQ-1:0] mask_o
);
  init_st_e st_q;
  logic     single_q;
  logic     need_mode_q;

  assign init_start_o = wr_i && !a0_i && wdata_i[4];
  assign running_o    = (st_q == INIT_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= INIT_IDLE;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      base_o      <= '0;
      cfg_o       <= '0;
      mask_o      <= '1;
    end else if (init_start_o) begin
      st_q        <= INIT_BASE;
      single_q    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
      cfg_o       <= '0;
      mask_o      <= '0;
    end else if (wr_i && a0_i) begin
      unique case (st_q)
        INIT_BASE: begin
          base_o <= wdata_i[N_IRQ-1:IW];
          if (!single_q)       st_q <= INIT_CASC;
          else if (need_mode_q) st_q <= INIT_MODE;
          else                 st_q <= INIT_RUN;
        end
        INIT_CASC: begin
          cfg_o <= role_master_i ? wdata_i : {{BW{1'b0}}, wdata_i[IW-1:0]};
          st_q  <= need_mode_q ? INIT_MODE : INIT_RUN;
        end
        INIT_MODE: st_q   <= INIT_RUN;
        INIT_RUN:  mask_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             a0_i,
  input  logic [N_IRQ-1:0] wdata_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             role_master_i,
  input  logic             inta_i,
  output logic             int_o,
  output logic [N_IRQ-1:0] vector_o,
  output logic [N_IRQ-1:0] cascade_cfg_o
);
  localparam int unsigned IW = $clog2(N_IRQ);
  localparam int unsigned BW = N_IRQ - IW;

  logic             running;
  logic             init_start;
  logic [BW-1:0]    base;
  logic [N_IRQ-1:0] imr, irr, isr, pend;
  logic [N_IRQ-1:0] pend_oh, isr_oh, sp_oh, ack_oh, eoi_clr;
  logic             pend_vld, isr_vld;
  logic [IW-1:0]    pend_idx, isr_idx;
  logic             cmd_wr, eoi_ns, eoi_sp, ack_take;

  pic_init_seq #(.N_IRQ(N_IRQ)) u_init (
    .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i, .role_master_i,
    .running_o(running), .init_start_o(init_start), .base_o(base),
    .cfg_o(cascade_cfg_o), .mask_o(imr)
  );

  pic_req_latch #(.N_IRQ(N_IRQ)) u_req (
    .clk_i, .rst_ni, .irq_i, .clr_all_i(init_start),
    .ack_clr_i(ack_oh), .irr_o(irr)
  );

  assign pend = irr & ~imr;

  pic_prio_enc #(.N_IRQ(N_IRQ)) u_pend_enc (
    .vec_i(pend), .vld_o(pend_vld), .idx_o(pend_idx), .oh_o(pend_oh)
  );

  pic_prio_enc #(.N_IRQ(N_IRQ)) u_isr_enc (
    .vec_i(isr), .vld_o(isr_vld), .idx_o(isr_idx), .oh_o(isr_oh)
  );

  // end-of-interrupt decode
  assign cmd_wr = running && wr_i && !a0_i && !wdata_i[4] && !wdata_i[3];
  assign eoi_ns = cmd_wr && (wdata_i[N_IRQ-1 -: 3] == OP_EOI_NS);
  assign eoi_sp = cmd_wr && (wdata_i[N_IRQ-1 -: 3] == OP_EOI_SP);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_sp
    assign sp_oh[g] = (wdata_i[IW-1:0] == IW'(g));
  end

  always_comb begin
    eoi_clr = '0;
    if (eoi_ns)      eoi_clr = isr_oh;
    else if (eoi_sp) eoi_clr = sp_oh;
  end

  assign ack_take = running && inta_i && pend_vld;
  assign ack_oh   = ack_take ? pend_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         isr <= '0;
    else if (init_start) isr <= '0;
    else                 isr <= (isr & ~eoi_clr) | ack_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vector_o <= '0;
    else if (running && inta_i)
      vector_o <= {base, pend_vld ? pend_idx : {IW{1'b1}}};
  end

  assign int_o = running && pend_vld && (!isr_vld || (pend_idx < isr_idx));
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = $clog2(N_IRQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             a0_i,
  input logic [N_IRQ-1:0] wdata_i,
  input logic             inta_i,
  input logic             int_o,
  input logic             running,
  input logic [N_IRQ-1:0] irr,
  input logic [N_IRQ-1:0] imr,
  input logic [N_IRQ-1:0] isr
);
  assert_quiet_in_init_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !int_o);

  assert_int_needs_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr) != '0));

  assert_mask_keeps_isr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && wr_i && a0_i && !inta_i) |=> (isr == $past(isr)));

  assert_ns_eoi_one_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && wr_i && !a0_i && wdata_i == 8'h20 && !inta_i) |=>
      ($countones(isr) + (($past(isr) != '0) ? 1 : 0) == $countones($past(isr))));

  assert_sp_eoi_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && wr_i && !a0_i && wdata_i[7:3] == 5'b01100 && !inta_i) |=>
      !isr[$past(wdata_i[IW-1:0])]);

  assert_ack_single_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> ($countones(isr & ~$past(isr)) <= 1));
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .a0_i(a0_i), .wdata_i(wdata_i),
  .inta_i(inta_i), .int_o(int_o), .running(running), .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/pic_ctrl_tb_top.sv
module pic_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, a0_i = 1'b0, role_master_i = 1'b1, inta_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic       int_o;
  logic [7:0] vector_o, cascade_cfg_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pic_ctrl dut_i (
    .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i, .irq_i, .role_master_i,
    .inta_i, .int_o, .vector_o, .cascade_cfg_o
  );

  // behavioural reference
  int         m_st = 0;  // 0 idle 1 base 2 cascade 3 mode 4 run
  bit         m_single = 0, m_need4 = 0;
  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 8'hFF, m_cfg = 0, m_vec = 0, m_prev = 0;
  logic [4:0] m_base = 0;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic m_int();
    return (m_st == 4) && (lowest(m_irr & ~m_imr) < lowest(m_isr));
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_st = 0; m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_cfg = 0; m_vec = 0; m_prev = 0; m_base = 0;
    end else begin
      automatic int p = lowest(m_irr & ~m_imr);
      automatic logic [7:0] nirr = m_irr | (irq_i & ~m_prev);
      automatic logic [7:0] nisr = m_isr;
      automatic bit run = (m_st == 4);
      m_prev = irq_i;
      if (run && inta_i) begin
        if (p < 8) begin nisr[p] = 1'b1; nirr[p] = 1'b0; m_vec = {m_base, 3'(p)}; end
        else m_vec = {m_base, 3'd7};
      end
      if (wr_i && !a0_i && wdata_i[4]) begin
        m_st = 1; m_single = wdata_i[1]; m_need4 = wdata_i[0];
        nirr = 0; nisr = 0; m_imr = 0; m_cfg = 0;
      end else if (wr_i && a0_i) begin
        case (m_st)
          1: begin m_base = wdata_i[7:3]; m_st = !m_single ? 2 : (m_need4 ? 3 : 4); end
          2: begin m_cfg = role_master_i ? wdata_i : {5'd0, wdata_i[2:0]}; m_st = m_need4 ? 3 : 4; end
          3: m_st = 4;
          4: m_imr = wdata_i;
          default: ;
        endcase
      end else if (wr_i && !a0_i && run) begin
        if (wdata_i == 8'h20) begin
          if (lowest(m_isr) < 8) nisr[lowest(m_isr)] = 1'b0;
        end else if (wdata_i[7:3] == 5'b01100) nisr[wdata_i[2:0]] = 1'b0;
      end
      m_irr = nirr; m_isr = nisr;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R8 int_o vs model", {7'd0, int_o}, {7'd0, m_int()});
      chk("R9 vector_o vs model", vector_o, m_vec);
      chk("R4 cascade_cfg_o vs model", cascade_cfg_o, m_cfg);
    end
  end

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    wr_i = 1'b1; a0_i = a0; wdata_i = d; tick(); wr_i = 1'b0;
  endtask

  task automatic pulse(input int n);
    irq_i[n] = 1'b1; tick(); irq_i[n] = 1'b0; tick();
  endtask

  task automatic ack();
    inta_i = 1'b1; tick(); inta_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1; tick();
    chk("R1 reset int_o", {7'd0, int_o}, 8'd0);
    chk("R1 reset vector_o", vector_o, 8'h00);
    chk("R1 reset cascade_cfg_o", cascade_cfg_o, 8'h00);
    wr(1'b1, 8'h00);
    pulse(0);
    chk("R1 no int before init", {7'd0, int_o}, 8'd0);

    // cascaded master with mode word
    role_master_i = 1'b1;
    wr(1'b0, 8'h11);
    irq_i[1] = 1'b1; tick();
    chk("R2 int held low during init", {7'd0, int_o}, 8'd0);
    wr(1'b1, 8'h20);
    chk("R2 int low after base word", {7'd0, int_o}, 8'd0);
    wr(1'b1, 8'h04);
    chk("R4 master cascade word", cascade_cfg_o, 8'h04);
    wr(1'b1, 8'h01);
    chk("R5 init complete on mode word", {7'd0, int_o}, 8'd1);
    irq_i[1] = 1'b0;
    ack();
    chk("R3 vector for input 1", vector_o, 8'h21);
    chk("R9 request cleared on ack", {7'd0, int_o}, 8'd0);

    pulse(3);
    chk("R8 lower blocked by in-service", {7'd0, int_o}, 8'd0);
    pulse(0);
    chk("R8 higher preempts in-service", {7'd0, int_o}, 8'd1);
    ack();
    chk("R9 vector for input 0", vector_o, 8'h20);
    wr(1'b0, 8'h20);
    pulse(0);
    chk("R10 nonspecific eoi cleared bit 0", {7'd0, int_o}, 8'd1);
    ack();
    wr(1'b0, 8'h61);
    wr(1'b0, 8'h60);
    chk("R11 specific eoi cleared bits 1 and 0", {7'd0, int_o}, 8'd1);
    ack();
    chk("R9 vector for input 3", vector_o, 8'h23);

    wr(1'b1, 8'h08);
    pulse(5);
    chk("R12 masked in-service still blocks", {7'd0, int_o}, 8'd0);
    wr(1'b0, 8'h63);
    chk("R12 masked in-service cleared by eoi", {7'd0, int_o}, 8'd1);
    ack();
    chk("R9 vector for input 5", vector_o, 8'h25);
    wr(1'b0, 8'h20);
    chk("R10 eoi leaves nothing pending", {7'd0, int_o}, 8'd0);

    pulse(3);
    chk("R6 masked request held", {7'd0, int_o}, 8'd0);
    wr(1'b1, 8'h00);
    chk("R6 unmask releases request", {7'd0, int_o}, 8'd1);
    ack(); wr(1'b0, 8'h20);

    irq_i[6] = 1'b1; tick();
    chk("R7 edge latched", {7'd0, int_o}, 8'd1);
    ack(); wr(1'b0, 8'h20); tick(); tick();
    chk("R7 held level gives one request", {7'd0, int_o}, 8'd0);
    irq_i[6] = 1'b0; tick();
    irq_i[6] = 1'b1; tick();
    chk("R7 new edge latched", {7'd0, int_o}, 8'd1);
    ack();
    chk("R9 vector for input 6", vector_o, 8'h26);
    irq_i[6] = 1'b0; wr(1'b0, 8'h20);

    ack();
    chk("R9 spurious ack vector", vector_o, 8'h27);

    pulse(2); ack();
    chk("R9 vector for input 2", vector_o, 8'h22);
    wr(1'b0, 8'h08);
    wr(1'b0, 8'h00);
    pulse(4);
    chk("R13 other commands leave in-service", {7'd0, int_o}, 8'd0);
    wr(1'b0, 8'h20);
    chk("R10 eoi releases input 4", {7'd0, int_o}, 8'd1);
    ack(); wr(1'b0, 8'h20);

    // cascaded slave
    role_master_i = 1'b0;
    wr(1'b0, 8'h11);
    chk("R2 restart clears cascade word", cascade_cfg_o, 8'h00);
    wr(1'b1, 8'h28);
    wr(1'b1, 8'hFA);
    chk("R4 slave reports id only", cascade_cfg_o, 8'h02);
    wr(1'b1, 8'h01);
    pulse(7);
    chk("R2 init words not taken as mask", {7'd0, int_o}, 8'd1);
    ack();
    chk("R3 slave vector for input 7", vector_o, 8'h2F);
    wr(1'b0, 8'h20);

    // single mode, no mode word
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'hFF);
    pulse(0);
    chk("R5 completes on base word, mask loaded", {7'd0, int_o}, 8'd0);
    wr(1'b1, 8'h00);
    chk("R5 unmasked after single-mode init", {7'd0, int_o}, 8'd1);
    chk("R4 single mode leaves cascade clear", cascade_cfg_o, 8'h00);
    ack();
    chk("R3 vector base 0x40", vector_o, 8'h40);
    tick();
    finish_run();
  end
endmodule